// File: doc/BRIEF.md
# Raster Timing Generator with Frame-Aligned Register Commit

This block drives a parallel RGB panel. From a pixel-clock strobe it derives horizontal sync, vertical sync and a data-enable window. For each pixel inside the active area it also produces the column and row coordinates. While the window is open it forwards 24-bit pixels from an input stream. When the layer is switched off it sends a programmable fill colour instead. It masks the pixel bus down to a selectable number of low-order bits.

Software writes sizes, porches, sync widths and the polarity word through a small write port. These writes go into a shadow set. Setting the commit flag in the control word arms a transfer. The whole shadow set moves into the working set on the last pixel strobe of the current frame, and the hardware then drops the flag, which software can watch on `go_busy`. While scanning is stopped, the transfer happens on the next clock.

Top module: `disp_timing_gen`

## Requirements
- R1: While reset is held and afterwards with scanning stopped, hsync, vsync, de, rgb, pos_x, pos_y and go_busy are all 0.
- R2: A line lasts width + (hsw+1) + (hbp+1) + (hfp+1) pixel strobes. hsync is active for the first hsw+1 of them. Address 1 holds hsw in [7:0], hfp in [19:8] and hbp in [31:20].
- R3: A frame lasts height + (vsw+1) + (vbp+1) + (vfp+1) lines. vsync is active for the first vsw+1 lines. Address 2 uses the same field layout as address 1.
- R4: Per frame, de together with pclk_en occurs exactly width*height times. pos_x counts 0..width-1 and pos_y counts 0..height-1 in raster order. Address 3 holds width-1 in [15:0] and height-1 in [31:16].
- R5: Writes to addresses 1 to 4 change neither the timing nor the polarity until a commit.
- R6: Writing address 0 with bit 1 set raises go_busy. While scanning, the shadow set is committed on the last strobe of the frame: go_busy falls there, and vsync rises one clock later with the new values. While stopped, go_busy falls one clock after the write.
- R7: Address 4 bits 0, 1 and 2 invert hsync, vsync and de respectively. With scanning stopped, the inverted idle levels appear on the outputs.
- R8: pclk_en pulses once every max(1,L)*max(1,P) clocks. Address 5 holds P in [7:0] and L in [23:16].
- R9: Inside de, rgb is pix_in when the layer bit (address 0, bit 2) is set and the fill colour (address 6, [23:0]) otherwise. rgb is 0 outside de. pix_take pulses once per displayed pixel only when the layer is on.
- R10: Address 0 bits [9:8] pick the kept low bits of rgb: 3 keeps 24, 2 keeps 18, 1 keeps 16 and 0 keeps 12. The bits above are zero.
- R11: Address 0 bit 0 starts scanning. When it is 0 the counters hold at zero and de stays inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | logic clock |
| rst | input | 1 | synchronous active-high reset |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | 3 | register address |
| wr_data | input | 32 | register write data |
| pix_in | input | 24 | pixel stream from the layer |
| go_busy | output | 1 | commit armed, not yet done |
| pclk_en | output | 1 | pixel strobe, aligned with outputs |
| pix_take | output | 1 | layer pixel consumed this clock |
| hsync | output | 1 | horizontal sync |
| vsync | output | 1 | vertical sync |
| de | output | 1 | data enable |
| rgb | output | 24 | pixel bus |
| pos_x | output | 16 | active column |
| pos_y | output | 16 | active row |

## Verification
The assertions check the following on every clock: the scan counters stay inside the totals of the working set, the working set changes only on the clock where go_busy falls, go_busy falls only at a frame end or while stopped, consecutive strobes are spaced whenever the divisor exceeds one, rgb is black outside the window, and de stays quiet while stopped. The bench scenarios are the only way to show the measured line and frame periods, the sync widths, the pixel counts and coordinates, the isolation of shadow writes made mid-frame, the polarity idle levels, the colour source and the bus masking.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    localparam int SIZE_W  = 16;
    localparam int PORCH_W = 12;
    localparam int SYNC_W  = 8;
    localparam int CNT_W   = 18;
    localparam int PIX_W   = 24;
    localparam int DIV_W   = 8;
    localparam int ADDR_W  = 3;

    localparam int FP_LSB  = 8;
    localparam int BP_LSB  = 20;
    localparam int HI_LSB  = 16;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_HTIM = 3'd1;
    localparam logic [ADDR_W-1:0] A_VTIM = 3'd2;
    localparam logic [ADDR_W-1:0] A_SIZE = 3'd3;
    localparam logic [ADDR_W-1:0] A_POL  = 3'd4;
    localparam logic [ADDR_W-1:0] A_DIV  = 3'd5;
    localparam logic [ADDR_W-1:0] A_FILL = 3'd6;

    typedef enum logic [1:0] {
        FMT_12 = 2'd0,
        FMT_16 = 2'd1,
        FMT_18 = 2'd2,
        FMT_24 = 2'd3
    } fmt_e;

    typedef struct packed {
        logic [SYNC_W-1:0]  sync;
        logic [PORCH_W-1:0] fp;
        logic [PORCH_W-1:0] bp;
        logic [SIZE_W-1:0]  last;
    } axis_t;

    typedef struct packed {
        logic hs;
        logic vs;
        logic de;
    } pol_t;

    typedef struct packed {
        axis_t h;
        axis_t v;
        pol_t  pol;
    } timing_t;

    typedef struct packed {
        logic [CNT_W-1:0] sync_end;
        logic [CNT_W-1:0] act_start;
        logic [CNT_W-1:0] act_end;
        logic [CNT_W-1:0] total;
    } bounds_t;

    localparam axis_t H_DEF = '{sync: SYNC_W'(95), fp: PORCH_W'(15),
                                bp: PORCH_W'(47), last: SIZE_W'(639)};
    localparam axis_t V_DEF = '{sync: SYNC_W'(2), fp: PORCH_W'(9),
                                bp: PORCH_W'(32), last: SIZE_W'(479)};
    localparam timing_t T_DEF = '{h: H_DEF, v: V_DEF, pol: '0};

    // Region edges along one axis; every field is stored as value minus one.
    function automatic bounds_t axis_bounds(axis_t a);
        bounds_t b;
        b.sync_end  = CNT_W'(a.sync) + CNT_W'(1);
        b.act_start = b.sync_end + CNT_W'(a.bp) + CNT_W'(1);
        b.act_end   = b.act_start + CNT_W'(a.last) + CNT_W'(1);
        b.total     = b.act_end + CNT_W'(a.fp) + CNT_W'(1);
        return b;
    endfunction

    function automatic int fmt_bits(fmt_e f);
        case (f)
            FMT_24:  return 24;
            FMT_18:  return 18;
            FMT_16:  return 16;
            default: return 12;
        endcase
    endfunction

    function automatic logic [PIX_W-1:0] mask_pixel(logic [PIX_W-1:0] p, fmt_e f);
        logic [PIX_W-1:0] m;
        for (int i = 0; i < PIX_W; i++) begin
            m[i] = (i < fmt_bits(f));
        end
        return p & m;
    endfunction

endpackage

// File: rtl/dtg_regs.sv
module dtg_regs
    import dtg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              frame_end,
    output timing_t           act,
    output logic              run,
    output logic              layer_on,
    output fmt_e              fmt,
    output logic [DIV_W-1:0]  ldiv,
    output logic [DIV_W-1:0]  pdiv,
    output logic [PIX_W-1:0]  fill,
    output logic              go_busy
);

    timing_t sh;
    logic    commit;

    assign commit = go_busy && (!run || frame_end);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh       <= T_DEF;
            act      <= T_DEF;
            run      <= 1'b0;
            layer_on <= 1'b0;
            fmt      <= FMT_24;
            ldiv     <= DIV_W'(1);
            pdiv     <= DIV_W'(1);
            fill     <= '0;
            go_busy  <= 1'b0;
        end else begin
            if (commit) begin
                act     <= sh;
                go_busy <= 1'b0;
            end
            if (wr_en) begin
                case (wr_addr)
                    A_CTRL: begin
                        run      <= wr_data[0];
                        layer_on <= wr_data[2];
                        fmt      <= fmt_e'(wr_data[9:8]);
                        if (wr_data[1]) go_busy <= 1'b1;
                    end
                    A_HTIM: begin
                        sh.h.sync <= wr_data[SYNC_W-1:0];
                        sh.h.fp   <= wr_data[FP_LSB +: PORCH_W];
                        sh.h.bp   <= wr_data[BP_LSB +: PORCH_W];
                    end
                    A_VTIM: begin
                        sh.v.sync <= wr_data[SYNC_W-1:0];
                        sh.v.fp   <= wr_data[FP_LSB +: PORCH_W];
                        sh.v.bp   <= wr_data[BP_LSB +: PORCH_W];
                    end
                    A_SIZE: begin
                        sh.h.last <= wr_data[SIZE_W-1:0];
                        sh.v.last <= wr_data[HI_LSB +: SIZE_W];
                    end
                    A_POL: begin
                        sh.pol.hs <= wr_data[0];
                        sh.pol.vs <= wr_data[1];
                        sh.pol.de <= wr_data[2];
                    end
                    A_DIV: begin
                        pdiv <= wr_data[DIV_W-1:0];
                        ldiv <= wr_data[HI_LSB +: DIV_W];
                    end
                    A_FILL: fill <= wr_data[PIX_W-1:0];
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/dtg_clkdiv.sv
module dtg_clkdiv
    import dtg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] ldiv,
    input  logic [DIV_W-1:0] pdiv,
    output logic             pen,
    output logic             multi
);

    logic [DIV_W-1:0] lcnt, pcnt, lmax, pmax;
    logic             lstep;

    assign lmax  = (ldiv == '0) ? '0 : ldiv - DIV_W'(1);
    assign pmax  = (pdiv == '0) ? '0 : pdiv - DIV_W'(1);
    assign lstep = (lcnt >= lmax);
    assign pen   = lstep && (pcnt >= pmax);
    assign multi = (lmax != '0) || (pmax != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            lcnt <= '0;
            pcnt <= '0;
        end else begin
            lcnt <= lstep ? '0 : lcnt + DIV_W'(1);
            if (lstep) pcnt <= (pcnt >= pmax) ? '0 : pcnt + DIV_W'(1);
        end
    end

endmodule

// File: rtl/dtg_scan.sv
module dtg_scan
    import dtg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              pen,
    input  timing_t           act,
    output logic [CNT_W-1:0]  hcnt,
    output logic [CNT_W-1:0]  vcnt,
    output logic              frame_end,
    output logic              hs_raw,
    output logic              vs_raw,
    output logic              de_raw,
    output logic [SIZE_W-1:0] xr,
    output logic [SIZE_W-1:0] yr
);

    bounds_t          hb, vb;
    logic             line_end, last_line;
    logic [CNT_W-1:0] xd, yd;

    assign hb        = axis_bounds(act.h);
    assign vb        = axis_bounds(act.v);
    assign line_end  = (hcnt == hb.total - CNT_W'(1));
    assign last_line = (vcnt == vb.total - CNT_W'(1));
    assign frame_end = run && pen && line_end && last_line;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            hcnt <= '0;
            vcnt <= '0;
        end else if (pen) begin
            if (line_end) begin
                hcnt <= '0;
                vcnt <= last_line ? '0 : vcnt + CNT_W'(1);
            end else begin
                hcnt <= hcnt + CNT_W'(1);
            end
        end
    end

    assign hs_raw = run && (hcnt < hb.sync_end);
    assign vs_raw = run && (vcnt < vb.sync_end);
    assign de_raw = run && (hcnt >= hb.act_start) && (hcnt < hb.act_end)
                        && (vcnt >= vb.act_start) && (vcnt < vb.act_end);
    assign xd     = hcnt - hb.act_start;
    assign yd     = vcnt - vb.act_start;
    assign xr     = xd[SIZE_W-1:0];
    assign yr     = yd[SIZE_W-1:0];

endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
    import dtg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [PIX_W-1:0]  pix_in,
    output logic              go_busy,
    output logic              pclk_en,
    output logic              pix_take,
    output logic              hsync,
    output logic              vsync,
    output logic              de,
    output logic [PIX_W-1:0]  rgb,
    output logic [SIZE_W-1:0] pos_x,
    output logic [SIZE_W-1:0] pos_y
);

    timing_t           act;
    logic              run, layer_on;
    fmt_e              fmt;
    logic [DIV_W-1:0]  ldiv, pdiv;
    logic [PIX_W-1:0]  fill;
    logic              pen, multi, frame_end;
    logic [CNT_W-1:0]  hcnt, vcnt;
    logic              hs_raw, vs_raw, de_raw;
    logic [SIZE_W-1:0] xr, yr;
    logic              de_q;

    dtg_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .frame_end(frame_end), .act(act), .run(run), .layer_on(layer_on),
        .fmt(fmt), .ldiv(ldiv), .pdiv(pdiv), .fill(fill), .go_busy(go_busy)
    );

    dtg_clkdiv u_div (
        .clk(clk), .rst(rst), .ldiv(ldiv), .pdiv(pdiv), .pen(pen), .multi(multi)
    );

    dtg_scan u_scan (
        .clk(clk), .rst(rst), .run(run), .pen(pen), .act(act),
        .hcnt(hcnt), .vcnt(vcnt), .frame_end(frame_end),
        .hs_raw(hs_raw), .vs_raw(vs_raw), .de_raw(de_raw), .xr(xr), .yr(yr)
    );

    assign pix_take = pen && de_raw && layer_on;

    // One output register stage keeps every panel pin aligned to the same clock.
    always_ff @(posedge clk) begin
        if (rst) begin
            de_q    <= 1'b0;
            pclk_en <= 1'b0;
            hsync   <= 1'b0;
            vsync   <= 1'b0;
            de      <= 1'b0;
            rgb     <= '0;
            pos_x   <= '0;
            pos_y   <= '0;
        end else begin
            de_q    <= de_raw;
            pclk_en <= pen;
            hsync   <= hs_raw ^ act.pol.hs;
            vsync   <= vs_raw ^ act.pol.vs;
            de      <= de_raw ^ act.pol.de;
            rgb     <= de_raw ? mask_pixel(layer_on ? pix_in : fill, fmt) : '0;
            pos_x   <= de_raw ? xr : '0;
            pos_y   <= de_raw ? yr : '0;
        end
    end

endmodule

// File: rtl/dtg_checker.sv
module dtg_checker
    import dtg_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             run,
    input logic             pen,
    input logic             multi,
    input logic             frame_end,
    input logic             go_busy,
    input timing_t          act,
    input logic [CNT_W-1:0] hcnt,
    input logic [CNT_W-1:0] vcnt,
    input logic             de_q,
    input logic [PIX_W-1:0] rgb
);

    p_hcnt_range_r2: assert property (@(posedge clk) disable iff (rst)
        hcnt < axis_bounds(act.h).total);

    p_vcnt_range_r3: assert property (@(posedge clk) disable iff (rst)
        vcnt < axis_bounds(act.v).total);

    p_act_commit_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(act) |-> $fell(go_busy));

    p_go_clear_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(go_busy) |-> ($past(frame_end) || !$past(run)));

    p_pclk_gap_r8: assert property (@(posedge clk) disable iff (rst)
        pen |=> (!pen || !multi));

    p_blank_black_r9: assert property (@(posedge clk) disable iff (rst)
        !de_q |-> (rgb == '0));

    p_idle_de_r11: assert property (@(posedge clk) disable iff (rst)
        !run |=> !de_q);

endmodule

bind disp_timing_gen dtg_checker u_chk (
    .clk(clk), .rst(rst), .run(run), .pen(pen), .multi(multi),
    .frame_end(frame_end), .go_busy(go_busy), .act(act),
    .hcnt(hcnt), .vcnt(vcnt), .de_q(de_q), .rgb(rgb)
);

// File: tb/disp_timing_gen_test.sv
module disp_timing_gen_test;

    typedef struct {
        int w, h, hs, hbp, hfp, vs, vbp, vfp, d;
    } mode_t;

    typedef struct {
        int hper, vper, de, hw, vw, w, take;
        logic [23:0] rgb;
        bit fmt_tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [23:0] pix_in = 24'hABCDEF;
    logic        go_busy, pclk_en, pix_take, hsync, vsync, de;
    logic [23:0] rgb;
    logic [15:0] pos_x, pos_y;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int nframes = 0;
    int pending = 0;
    exp_t q[$];

    always #2.5 clk = ~clk;

    disp_timing_gen uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pix_in(pix_in), .go_busy(go_busy), .pclk_en(pclk_en), .pix_take(pix_take),
        .hsync(hsync), .vsync(vsync), .de(de), .rgb(rgb), .pos_x(pos_x), .pos_y(pos_y)
    );

    task automatic check(string r, int a, int e);
        total++;
        if (a !== e) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", r, a, e);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_mode(mode_t m);
        wr(3'd1, 32'((m.hbp << 20) | (m.hfp << 8) | m.hs));
        wr(3'd2, 32'((m.vbp << 20) | (m.vfp << 8) | m.vs));
        wr(3'd3, 32'(((m.h - 1) << 16) | (m.w - 1)));
    endtask

    function automatic exp_t mk(mode_t m, logic [23:0] c, bit ft, bit take_on);
        exp_t e;
        e.hper = (m.w + m.hs + m.hbp + m.hfp + 3) * m.d;
        e.vper = e.hper * (m.h + m.vs + m.vbp + m.vfp + 3);
        e.de = m.w * m.h;
        e.hw = (m.hs + 1) * m.d;
        e.vw = (m.vs + 1) * e.hper;
        e.w = m.w;
        e.take = take_on ? m.w * m.h : 0;
        e.rgb = c;
        e.fmt_tag = ft;
        return e;
    endfunction

    // driver: wait for a clean frame start, then push the frames to expect
    task automatic expect_frames(exp_t e, int n);
        int n0;
        n0 = nframes;
        wait (nframes == n0 + 1);
        for (int i = 0; i < n; i++) begin
            q.push_back(e);
            pending++;
        end
        wait (pending == 0);
    endtask

    // monitor
    int t_hr = 0, t_vr = 0, hper = 0, hw = 0, vw = 0;
    int de_cnt = 0, take_cnt = 0, pos_err = 0, rgb_err = 0;
    logic p_hs = 1'b0, p_vs = 1'b0;

    always @(negedge clk) begin
        exp_t e;
        cyc++;
        if (rst) begin
            p_hs = 1'b0; p_vs = 1'b0;
        end else begin
            if (hsync && !p_hs) begin hper = cyc - t_hr; t_hr = cyc; end
            if (!hsync && p_hs) hw = cyc - t_hr;
            if (vsync && !p_vs) begin
                if (pending > 0) begin
                    e = q.pop_front();
                    check("R2 hsync period", hper, e.hper);
                    check("R2 hsync width", hw, e.hw);
                    check("R3 vsync period", cyc - t_vr, e.vper);
                    check("R3 vsync width", vw, e.vw);
                    check("R4 de strobes per frame", de_cnt, e.de);
                    check("R4 coordinate errors", pos_err, 0);
                    check("R9 pixel take count", take_cnt, e.take);
                    if (e.fmt_tag) check("R10 masked rgb errors", rgb_err, 0);
                    else           check("R9 rgb source errors", rgb_err, 0);
                    pending--;
                end
                t_vr = cyc;
                de_cnt = 0; take_cnt = 0; pos_err = 0; rgb_err = 0;
                nframes++;
            end
            if (!vsync && p_vs) vw = cyc - t_vr;
            if (pending > 0) begin
                if (de && pclk_en) begin
                    if (pos_x != 16'(de_cnt % q[0].w) || pos_y != 16'(de_cnt / q[0].w))
                        pos_err++;
                    de_cnt++;
                end
                if (de && rgb != q[0].rgb) rgb_err++;
                if (!de && rgb != 24'h0) rgb_err++;
                if (pix_take) take_cnt++;
            end
            p_hs = hsync; p_vs = vsync;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        mode_t ma, mb, md;
        int gap;
        ma = '{w: 8, h: 4, hs: 1, hbp: 2, hfp: 0, vs: 0, vbp: 1, vfp: 1, d: 1};
        mb = '{w: 5, h: 3, hs: 0, hbp: 0, hfp: 2, vs: 1, vbp: 0, vfp: 0, d: 2};

        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 hsync", hsync, 0);
        check("R1 vsync", vsync, 0);
        check("R1 de", de, 0);
        check("R1 rgb", rgb, 0);
        check("R1 go_busy", go_busy, 0);
        check("R1 pos", pos_x + pos_y, 0);

        // program mode A while stopped; commit is immediate (R6)
        set_mode(ma);
        wr(3'd4, 32'h0);
        wr(3'd5, 32'h0001_0001);
        wr(3'd6, 32'h00FF_0000);
        wr(3'd0, 32'h306);
        check("R6 go_busy raised", go_busy, 1);
        @(negedge clk);
        check("R6 idle commit clears go", go_busy, 0);
        repeat (5) @(negedge clk);
        check("R11 stopped hsync", hsync, 0);
        check("R11 stopped de", de, 0);

        // run mode A, layer on, 24-bit
        wr(3'd0, 32'h305);
        expect_frames(mk(ma, 24'hABCDEF, 1'b0, 1'b1), 2);

        // R5: mid-frame writes of mode B timing, no commit
        repeat (20) @(negedge clk);
        set_mode(mb);
        wr(3'd4, 32'h7);
        expect_frames(mk(ma, 24'hABCDEF, 1'b0, 1'b1), 2);
        wr(3'd4, 32'h0);

        // R9 fill colour with 18-bit mask (R10)
        wr(3'd0, 32'h201);
        expect_frames(mk(ma, 24'h030000, 1'b1, 1'b0), 1);
        wr(3'd6, 32'h0012_3456);
        wr(3'd0, 32'h101);
        expect_frames(mk(ma, 24'h003456, 1'b1, 1'b0), 1);

        // R6: commit mode B mid-frame while scanning
        repeat (20) @(negedge clk);
        wr(3'd5, 32'h0001_0002);
        wr(3'd0, 32'h307);
        check("R6 go_busy after write", go_busy, 1);
        repeat (10) @(negedge clk);
        check("R6 go_busy held mid-frame", go_busy, 1);
        while (go_busy) @(negedge clk);
        check("R6 vsync before commit edge", vsync, 0);
        @(negedge clk);
        check("R6 vsync one clock after go clears", vsync, 1);
        expect_frames(mk(mb, 24'hABCDEF, 1'b0, 1'b1), 2);

        // R7 polarity: shadowed write, then stop, then commit while stopped
        wr(3'd4, 32'h7);
        wr(3'd0, 32'h304);
        repeat (2) @(negedge clk);
        check("R5 polarity not yet applied hsync", hsync, 0);
        check("R5 polarity not yet applied de", de, 0);
        wr(3'd0, 32'h306);
        repeat (2) @(negedge clk);
        check("R7 inverted hsync idle", hsync, 1);
        check("R7 inverted vsync idle", vsync, 1);
        check("R7 inverted de idle", de, 1);
        check("R9 rgb black outside window", rgb, 0);
        wr(3'd4, 32'h0);
        wr(3'd0, 32'h306);
        repeat (2) @(negedge clk);
        check("R7 normal de idle", de, 0);

        // R8 divisor spacing
        wr(3'd5, 32'h0002_0003);
        repeat (12) @(negedge clk);
        while (!pclk_en) @(negedge clk);
        gap = 0;
        do begin @(negedge clk); gap++; end while (!pclk_en);
        check("R8 strobe spacing 2x3", gap, 6);
        wr(3'd5, 32'h0);
        repeat (4) @(negedge clk);
        while (!pclk_en) @(negedge clk);
        gap = 0;
        do begin @(negedge clk); gap++; end while (!pclk_en);
        check("R8 zero divisors act as one", gap, 1);

        // back to mode A with 12-bit bus (R10)
        md = ma;
        set_mode(ma);
        wr(3'd5, 32'h0001_0001);
        wr(3'd0, 32'h006);
        @(negedge clk);
        wr(3'd0, 32'h005);
        expect_frames(mk(md, 24'h000DEF, 1'b1, 1'b1), 2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule